// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between the execute stage of a RISC core and a 32-bit data memory that is addressed by word. For every memory instruction it adds a sign-extended 16-bit displacement to a base register, hands the upper address bits to memory as a word index, and uses the two low bits to pick the byte lane. It is purely combinational: results follow the inputs with no register on the way.

For stores it copies the byte or halfword of the source register into every lane that could hold it and raises write enables only for the lanes being written. For loads it shifts the addressed byte or halfword of the memory word down to bit 0 and then extends it with the sign bit or with zeros, depending on the opcode. If a halfword or word access is not on its natural boundary, a fault flag is raised and nothing is written or returned.

Top module: `ldst_align`

## Requirements
- R1: The effective address is `base` plus `disp` sign-extended to 32 bits, with the sum taken modulo 2^32. `word_addr` carries bits 31:2 of that sum for every opcode.
- R2: Opcode 0x20 returns the addressed byte sign-extended, and opcode 0x24 returns it zero-extended. The lane is little-endian: effective-address bits 1:0 equal to n select `rd_word` bits 8n+7:8n.
- R3: Opcode 0x21 returns the addressed halfword sign-extended, and opcode 0x25 returns it zero-extended. Address bit 1 clear selects bits 15:0 and address bit 1 set selects bits 31:16.
- R4: Opcode 0x23 at an address whose two low bits are zero returns `rd_word` unchanged.
- R5: Opcode 0x28 drives the low byte of `st_data` into all four byte positions of `wr_data` and sets exactly one bit of `lane_we`, the bit at effective-address bits 1:0.
- R6: Opcode 0x29 drives the low halfword of `st_data` into both halves of `wr_data`. `lane_we` is 4'b0011 when address bit 1 is clear and 4'b1100 when it is set.
- R7: Opcode 0x2b at an address whose two low bits are zero drives `st_data` onto `wr_data` and sets `lane_we` to 4'b1111.
- R8: A halfword access (0x21, 0x25 or 0x29) with address bit 0 set, or a word access (0x23 or 0x2b) with either low address bit set, sets `misalign`. It also forces `lane_we` to zero and `ld_data` to zero. Byte accesses never fault.
- R9: Any opcode other than the eight above gives `lane_we` = 0, `ld_data` = 0, `wr_data` = 0 and `misalign` = 0.
- R10: Load opcodes never set any bit of `lane_we`, and store opcodes always give `ld_data` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 6 | Primary opcode of the instruction |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement field |
| st_data | input | 32 | Store source register value |
| rd_word | input | 32 | Word read from data memory |
| word_addr | output | 30 | Word index into data memory |
| lane_we | output | 4 | Byte-lane write enables, bit n for bits 8n+7:8n |
| wr_data | output | 32 | Lane-replicated write data |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Alignment fault |

## Verification
Every output is a combinational function of the inputs that are applied in the same cycle, so a result is due zero clock edges after its stimulus. The bench changes the inputs just after a rising edge and samples all five outputs at the following falling edge, half a period later, so no check depends on event ordering at an edge. The sweep covers every one of the 64 opcodes against all four low-address residues, three displacements (zero, small negative and maximum positive) and two data patterns, one with the sign bits set and one with them clear. Expected values are derived in the bench using lane indexing.

// File: rtl/ldst_align.sv
module ldst_align #(
  parameter int XW = 32,
  parameter int IW = 16
) (
  input  logic [5:0]        op,
  input  logic [XW-1:0]     base,
  input  logic [IW-1:0]     disp,
  input  logic [XW-1:0]     st_data,
  input  logic [XW-1:0]     rd_word,
  output logic [XW-3:0]     word_addr,
  output logic [XW/8-1:0]   lane_we,
  output logic [XW-1:0]     wr_data,
  output logic [XW-1:0]     ld_data,
  output logic              misalign
);
  localparam int NL = XW / 8;
  localparam logic [5:0] OP_LB  = 6'h20, OP_LH  = 6'h21, OP_LW = 6'h23,
                         OP_LBU = 6'h24, OP_LHU = 6'h25,
                         OP_SB  = 6'h28, OP_SH  = 6'h29, OP_SW = 6'h2b;

  logic [XW-1:0] ea;
  logic [1:0]    lane;
  logic [XW-1:0] rd_shift;
  logic          is_ld, is_st, uns;
  logic [1:0]    sz;
  logic [NL-1:0] mask;

  assign ea        = base + {{(XW-IW){disp[IW-1]}}, disp};
  assign lane      = ea[1:0];
  assign word_addr = ea[XW-1:2];
  assign rd_shift  = rd_word >> {lane, 3'b000};

  always_comb begin
    is_ld = 1'b0;
    is_st = 1'b0;
    uns   = 1'b0;
    sz    = 2'd0;
    case (op)
      OP_LB:  begin is_ld = 1'b1; sz = 2'd0; end
      OP_LBU: begin is_ld = 1'b1; sz = 2'd0; uns = 1'b1; end
      OP_LH:  begin is_ld = 1'b1; sz = 2'd1; end
      OP_LHU: begin is_ld = 1'b1; sz = 2'd1; uns = 1'b1; end
      OP_LW:  begin is_ld = 1'b1; sz = 2'd2; end
      OP_SB:  begin is_st = 1'b1; sz = 2'd0; end
      OP_SH:  begin is_st = 1'b1; sz = 2'd1; end
      OP_SW:  begin is_st = 1'b1; sz = 2'd2; end
      default: ;
    endcase
  end

  assign misalign = (is_ld | is_st) &
                    (((sz == 2'd1) & lane[0]) | ((sz == 2'd2) & (lane != 2'd0)));

  always_comb begin
    case (sz)
      2'd0:    mask = 4'b0001;
      2'd1:    mask = 4'b0011;
      default: mask = 4'b1111;
    endcase
  end

  assign lane_we = (is_st & ~misalign) ? NL'(mask << lane) : '0;

  always_comb begin
    wr_data = '0;
    if (is_st) begin
      case (sz)
        2'd0:    wr_data = {NL{st_data[7:0]}};
        2'd1:    wr_data = {(NL/2){st_data[15:0]}};
        default: wr_data = st_data;
      endcase
    end
  end

  always_comb begin
    ld_data = '0;
    if (is_ld & ~misalign) begin
      case (sz)
        2'd0:    ld_data = {{(XW-8){~uns & rd_shift[7]}}, rd_shift[7:0]};
        2'd1:    ld_data = {{(XW-16){~uns & rd_shift[15]}}, rd_shift[15:0]};
        default: ld_data = rd_word;
      endcase
    end
  end
endmodule

// File: rtl/ldst_align_chk.sv
module ldst_align_chk (
  input logic [5:0]  op,
  input logic [31:0] base,
  input logic [15:0] disp,
  input logic [31:0] st_data,
  input logic [31:0] rd_word,
  input logic [29:0] word_addr,
  input logic [3:0]  lane_we,
  input logic [31:0] wr_data,
  input logic [31:0] ld_data,
  input logic        misalign
);
  logic mem_op, ld_op;
  assign ld_op  = (op == 6'h20) || (op == 6'h21) || (op == 6'h23) ||
                  (op == 6'h24) || (op == 6'h25);
  assign mem_op = ld_op || (op == 6'h28) || (op == 6'h29) || (op == 6'h2b);

  always_comb begin
    if (misalign) AST_FAULT_QUIET: assert (lane_we == 4'b0 && ld_data == 32'b0); // R8
    if (!mem_op) AST_NONMEM_IDLE: assert (lane_we == 4'b0 && ld_data == 32'b0 && wr_data == 32'b0 && !misalign); // R9
    if (ld_op) AST_LOAD_NO_WRITE: assert (lane_we == 4'b0); // R10
    if (op == 6'h28) AST_BYTE_ONE_LANE: assert ($onehot(lane_we) && wr_data[31:24] == st_data[7:0]); // R5
    if (op == 6'h24) AST_UBYTE_ZERO_TOP: assert (ld_data[31:8] == 24'b0); // R2
    if (op == 6'h2b && !misalign) AST_WORD_STORE_FULL: assert (lane_we == 4'hF && wr_data == st_data); // R7
    if (op == 6'h23 && !misalign) AST_WORD_LOAD_PASS: assert (ld_data == rd_word); // R4
    if (disp == 16'h0) AST_ZERO_DISP_ADDR: assert (word_addr == base[31:2]); // R1
  end
endmodule

bind ldst_align ldst_align_chk u_chk (.*);

// File: tb/sim_ldst_align.sv
module sim_ldst_align;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [5:0]  op;
  logic [31:0] base, st_data, rd_word;
  logic [15:0] disp;
  logic [29:0] word_addr;
  logic [3:0]  lane_we;
  logic [31:0] wr_data, ld_data;
  logic        misalign;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  ldst_align u0 (.op, .base, .disp, .st_data, .rd_word,
                 .word_addr, .lane_we, .wr_data, .ld_data, .misalign);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s op=%02h base=%08h disp=%04h act=%08h exp=%08h",
               req, what, op, base, disp, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      finish_run();
    end
  end

  task automatic apply_and_check(input logic [5:0] o, input logic [31:0] b, input logic [15:0] d,
                                 input logic [31:0] s, input logic [31:0] r);
    logic [31:0] ea, e_ld, e_wr;
    logic [3:0]  e_we;
    logic        e_flt;
    int          l, w;
    string       tag;
    @(posedge clk);
    op = o; base = b; disp = d; st_data = s; rd_word = r;
    ea = b + 32'($signed(d));
    l  = int'(ea[1:0]);
    w  = 0;
    tag = "R9";
    case (o)
      6'h20, 6'h24, 6'h28: begin w = 1; tag = (o == 6'h28) ? "R5" : "R2"; end
      6'h21, 6'h25, 6'h29: begin w = 2; tag = (o == 6'h29) ? "R6" : "R3"; end
      6'h23, 6'h2b:        begin w = 4; tag = (o == 6'h2b) ? "R7" : "R4"; end
      default: ;
    endcase
    e_flt = (w != 0) && (l % w != 0);
    if (e_flt) tag = "R8";
    e_ld = 32'h0; e_wr = 32'h0; e_we = 4'h0;
    if (!e_flt) begin
      case (o)
        6'h20: e_ld = 32'($signed(r[8*l +: 8]));
        6'h24: e_ld = {24'h0, r[8*l +: 8]};
        6'h21: e_ld = 32'($signed(r[8*l +: 16]));
        6'h25: e_ld = {16'h0, r[8*l +: 16]};
        6'h23: e_ld = r;
        default: ;
      endcase
      if (o == 6'h28 || o == 6'h29 || o == 6'h2b)
        for (int k = 0; k < 4; k++) e_we[k] = (k >= l) && (k < l + w);
    end
    case (o)
      6'h28: for (int k = 0; k < 4; k++) e_wr[8*k +: 8] = s[7:0];
      6'h29: for (int k = 0; k < 2; k++) e_wr[16*k +: 16] = s[15:0];
      6'h2b: e_wr = s;
      default: ;
    endcase
    @(negedge clk);
    chk("R1", "word_addr", {2'b00, word_addr}, {2'b00, ea[31:2]});
    chk(tag, "misalign", {31'h0, misalign}, {31'h0, e_flt});
    chk((w != 0 && o < 6'h28) ? "R10" : tag, "lane_we", {28'h0, lane_we}, {28'h0, e_we});
    chk(tag, "wr_data", wr_data, e_wr);
    chk((o >= 6'h28 && w != 0) ? "R10" : tag, "ld_data", ld_data, e_ld);
  endtask

  initial begin
    op = '0; base = '0; disp = '0; st_data = '0; rd_word = '0;
    @(negedge clk);
    // idle state with all inputs zero: non-memory opcode 0 (R9)
    chk("R9", "idle lane_we", {28'h0, lane_we}, 32'h0);
    chk("R9", "idle ld_data", ld_data, 32'h0);
    chk("R1", "idle word_addr", {2'b00, word_addr}, 32'h0);
    // R1 wrap-around: negative displacement below zero
    apply_and_check(6'h23, 32'h0000_0004, 16'hFFF8, 32'h0, 32'h1234_5678);
    for (int o = 0; o < 64; o++)
      for (int lo = 0; lo < 4; lo++)
        for (int dsel = 0; dsel < 3; dsel++)
          for (int pat = 0; pat < 2; pat++) begin
            logic [15:0] d;
            logic [31:0] b;
            d = (dsel == 0) ? 16'h0000 : (dsel == 1) ? 16'hFFFD : 16'h7FFF;
            b = 32'h4000_1000 + 32'(lo) - 32'($signed(d)) + 32'(dsel * 4);
            b[1:0] = 2'(lo) - d[1:0];
            apply_and_check(6'(o), b, d,
                            pat == 0 ? 32'h8A7F_C3E1 : 32'h1122_3344,
                            pat == 0 ? 32'hF08C_81A7 : 32'h6B2D_4E19);
          end
    finish_run();
  end
endmodule